// File: doc/BRIEF.md
# Multi-Mode Lane Clock-Crossing FIFO

This block carries parallel lane words from a fabric-side write clock to a transceiver-side read clock. A two-bit mode code, captured while reset is held, picks one of three behaviours. In phase-compensation mode both clocks run at the same rate. Reads begin once the buffer is half full and then go on every cycle, so the fill level stays put and the enables can be tied high. In basic mode the two clocks are unrelated. The writer pushes while the partial-full flag is low and the reader pulls while the partial-empty flag is low. In register mode the storage is skipped and each word passes through one flop clocked by a single shared clock.

Pointers cross between the domains as Gray codes through two-stage synchronisers. Each side works out its own occupancy from its own pointer and the synchronised copy of the other pointer. A registered valid strobe marks every word on the read data bus, and downstream logic must drop words shown while the strobe is low. Sticky overflow and underflow bits record attempts to write a full buffer or to read an empty one. Such attempts are ignored.

Top module: `lane_fifo`

## Requirements
- R1: The mode code is captured on every clock edge where that side's reset is high: 0 selects phase compensation, 1 selects basic, and 2 or 3 select register mode. Changes to the code while reset is low have no effect.
- R2: In phase-compensation mode, read requests are ignored until the read-side occupancy has reached DEPTH/2 once after reset. From the next cycle on, each request with data present produces a valid word, in write order.
- R3: A write request while the write side sees DEPTH words stored is dropped and sets a sticky overflow bit. Only reset clears that bit.
- R4: An enabled read request while the read side sees zero words is dropped and sets a sticky underflow bit. Only reset clears that bit. In phase mode a request counts as enabled only after the start of R2.
- R5: In basic mode with unrelated clocks, a writer throttled by partial-full and a reader throttled by partial-empty (then by empty to drain) receive every word once, in order, with neither sticky bit set.
- R6: Partial-full is high exactly when the write-side occupancy is at least DEPTH-PFULL_GAP.
- R7: The read side's empty flag is high when its occupancy is 0, and partial-empty is high when it is at most PEMPTY_LVL. A write becomes visible in read-side occupancy on the second read edge after the write edge.
- R8: Full is high exactly when the write-side occupancy equals DEPTH. The write side sees a read on the second write edge after the read edge.
- R9: In register mode, read data and valid equal the write data and write enable of the previous clock edge. Nothing is stored, so empty stays high and full stays low.
- R10: In the FIFO modes, valid rises on the read edge after an accepted read and stays high for one cycle. Read data holds its value while no read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_sel | input | 2 | Mode code, captured during reset |
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write word |
| wr_full | output | 1 | Write-side occupancy equals DEPTH |
| wr_pfull | output | 1 | Write-side occupancy at or above DEPTH-PFULL_GAP |
| wr_overflow | output | 1 | Sticky: write attempted while full |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Read word |
| rd_valid | output | 1 | Qualifies rd_data |
| rd_empty | output | 1 | Read-side occupancy is zero |
| rd_pempty | output | 1 | Read-side occupancy at or below PEMPTY_LVL |
| rd_underflow | output | 1 | Sticky: enabled read attempted while empty |

## Verification
The bench builds the block with its defaults: WIDTH 32, DEPTH 16, PFULL_GAP 4 and PEMPTY_LVL 4. Sixteen entries let a short burst reach full, overflow, the half-depth start and both partial thresholds within a few dozen cycles, so a cycle-exact model can follow every flag under a shared clock. Two unrelated clock ratios, with the reader both slower and faster than the writer, then test the throttled transfer of R5. That run drives the Gray pointer crossing in both directions.

// File: rtl/lane_fifo_pkg.sv
package lane_fifo_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        MODE_PHASE = 2'd0,
        MODE_BASIC = 2'd1,
        MODE_REG   = 2'd2
    } lane_mode_e;

    typedef struct packed {
        logic full;
        logic pfull;
        logic overflow;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic pempty;
        logic underflow;
    } rd_flags_t;

    // codes 2 and 3 both select the bypass register
    function automatic lane_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd0:    return MODE_PHASE;
            2'd1:    return MODE_BASIC;
            default: return MODE_REG;
        endcase
    endfunction
endpackage

// File: rtl/lane_fifo_sync.sv
module lane_fifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lane_fifo_wr.sv
module lane_fifo_wr
    import lane_fifo_pkg::*;
#(
    parameter  int DEPTH     = 16,
    parameter  int PFULL_GAP = 4,
    localparam int AW        = $clog2(DEPTH),
    localparam int PW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode_sel,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_s,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output wr_flags_t     flags
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [PW-1:0] FULL_LVL  = PW'(DEPTH);
    localparam logic [PW-1:0] PFULL_LVL = PW'(DEPTH - PFULL_GAP);

    lane_mode_e    mode_q;
    logic [PW-1:0] wptr, wptr_nxt, wgray_q, rptr_b, occ;
    logic          ovf_q, full_c, pfull_c;

    always_comb begin
        for (int i = 0; i < PW; i++) rptr_b[i] = ^(rgray_s >> i);
        occ      = wptr - rptr_b;
        full_c   = (occ == FULL_LVL);
        pfull_c  = (occ >= PFULL_LVL);
        push     = wr_en && !full_c && (mode_q != MODE_REG);
        wptr_nxt = wptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= decode_mode(mode_sel);
            wptr    <= '0;
            wgray_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (push) begin
                wptr    <= wptr_nxt;
                wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
            end
            if (wr_en && full_c && (mode_q != MODE_REG)) ovf_q <= 1'b1;
        end
    end

    assign waddr          = wptr[AW-1:0];
    assign wgray          = wgray_q;
    assign flags.full     = full_c;
    assign flags.pfull    = pfull_c;
    assign flags.overflow = ovf_q;

    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    assert_wr_occupancy_R8: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_LVL);
    assert_gray_onebit_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/lane_fifo_rd.sv
module lane_fifo_rd
    import lane_fifo_pkg::*;
#(
    parameter  int DEPTH      = 16,
    parameter  int WIDTH      = 32,
    parameter  int PEMPTY_LVL = 4,
    localparam int AW         = $clog2(DEPTH),
    localparam int PW         = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             rd_en,
    input  logic [PW-1:0]    wgray_s,
    input  logic [WIDTH-1:0] mem_word,
    input  logic [WIDTH-1:0] thru_word,
    input  logic             thru_valid,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rgray,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output rd_flags_t        flags
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);
    localparam logic [PW-1:0] PE_LVL   = PW'(PEMPTY_LVL);

    lane_mode_e    mode_q;
    logic [PW-1:0] rptr, rptr_nxt, rgray_q, wptr_b, occ;
    logic          started_q, unf_q, req, fire, empty_c, pempty_c;

    always_comb begin
        for (int i = 0; i < PW; i++) wptr_b[i] = ^(wgray_s >> i);
        occ      = wptr_b - rptr;
        empty_c  = (occ == '0);
        pempty_c = (occ <= PE_LVL);
        req      = rd_en && ((mode_q == MODE_BASIC) ||
                             ((mode_q == MODE_PHASE) && started_q));
        fire     = req && !empty_c;
        rptr_nxt = rptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= decode_mode(mode_sel);
            rptr      <= '0;
            rgray_q   <= '0;
            started_q <= 1'b0;
            unf_q     <= 1'b0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
        end else if (mode_q == MODE_REG) begin
            rd_data  <= thru_word;
            rd_valid <= thru_valid;
        end else begin
            rd_valid <= fire;
            if (fire) begin
                rd_data <= mem_word;
                rptr    <= rptr_nxt;
                rgray_q <= rptr_nxt ^ (rptr_nxt >> 1);
            end
            if (req && empty_c) unf_q <= 1'b1;
            if ((mode_q == MODE_PHASE) && (occ >= HALF_LVL)) started_q <= 1'b1;
        end
    end

    assign raddr           = rptr[AW-1:0];
    assign rgray           = rgray_q;
    assign flags.empty     = empty_c;
    assign flags.pempty    = pempty_c;
    assign flags.underflow = unf_q;

    assert_phase_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PHASE && !started_q) |=> !rd_valid);
    assert_underflow_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        unf_q |=> unf_q);
    assert_rd_occupancy_R7: assert property (@(posedge clk) disable iff (rst)
        occ <= PW'(DEPTH));
    assert_reg_no_storage_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_REG) |-> empty_c);
endmodule

// File: rtl/lane_fifo.sv
module lane_fifo
    import lane_fifo_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter int DEPTH      = 16,
    parameter int PFULL_GAP  = 4,
    parameter int PEMPTY_LVL = 4
) (
    input  logic [1:0]       mode_sel,
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_full,
    output logic             wr_pfull,
    output logic             wr_overflow,
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             rd_empty,
    output logic             rd_pempty,
    output logic             rd_underflow
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic             push;
    logic [AW-1:0]    waddr, raddr;
    logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
    logic [WIDTH-1:0] mem_word;
    wr_flags_t        wflags;
    rd_flags_t        rflags;

    lane_fifo_wr #(.DEPTH(DEPTH), .PFULL_GAP(PFULL_GAP)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .mode_sel(mode_sel), .wr_en(wr_en),
        .rgray_s(rgray_s), .push(push), .waddr(waddr), .wgray(wgray),
        .flags(wflags)
    );

    lane_fifo_sync #(.W(PW), .STAGES(2)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
    );

    lane_fifo_sync #(.W(PW), .STAGES(2)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
    );

    always_ff @(posedge wr_clk) begin
        if (push) mem[waddr] <= wr_data;
    end

    assign mem_word = mem[raddr];

    lane_fifo_rd #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PEMPTY_LVL(PEMPTY_LVL)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .mode_sel(mode_sel), .rd_en(rd_en),
        .wgray_s(wgray_s), .mem_word(mem_word), .thru_word(wr_data),
        .thru_valid(wr_en), .raddr(raddr), .rgray(rgray), .rd_data(rd_data),
        .rd_valid(rd_valid), .flags(rflags)
    );

    assign wr_full      = wflags.full;
    assign wr_pfull     = wflags.pfull;
    assign wr_overflow  = wflags.overflow;
    assign rd_empty     = rflags.empty;
    assign rd_pempty    = rflags.pempty;
    assign rd_underflow = rflags.underflow;
endmodule

// File: tb/lane_fifo_test.sv
module lane_fifo_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WIDTH = 32;
    localparam int DEPTH = 16;
    localparam int GAP   = 4;
    localparam int PEL   = 4;
    localparam int HALF  = DEPTH / 2;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    realtime b_half = 5.3;
    logic split = 1'b0;
    logic rd_clk;
    always #4 clk_a = ~clk_a;
    always #(b_half) clk_b = ~clk_b;
    assign rd_clk = split ? clk_b : clk_a;

    logic [1:0]       mode_sel = 2'd0;
    logic             wr_rst = 1'b1, rd_rst = 1'b1;
    logic             wr_en = 1'b0, rd_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             wr_full, wr_pfull, wr_overflow;
    logic [WIDTH-1:0] rd_data;
    logic             rd_valid, rd_empty, rd_pempty, rd_underflow;

    lane_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PFULL_GAP(GAP), .PEMPTY_LVL(PEL)) uut (
        .mode_sel(mode_sel), .wr_clk(clk_a), .wr_rst(wr_rst), .wr_en(wr_en),
        .wr_data(wr_data), .wr_full(wr_full), .wr_pfull(wr_pfull),
        .wr_overflow(wr_overflow), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_empty(rd_empty), .rd_pempty(rd_pempty), .rd_underflow(rd_underflow)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference for the shared-clock runs
    bit model_on = 1'b0, primed = 1'b0;
    int W, R, Wd1, Wd2, Rd1, Rd2, mode_m;
    bit started_m, ovf_m, unf_m, val_m;
    logic [WIDTH-1:0] dat_m;
    logic [WIDTH-1:0] q[$];

    always @(posedge clk_a) begin
        if (model_on) begin
            if (wr_rst) begin
                W = 0; R = 0; Wd1 = 0; Wd2 = 0; Rd1 = 0; Rd2 = 0;
                mode_m = (mode_sel >= 2) ? 2 : int'(mode_sel);
                started_m = 0; ovf_m = 0; unf_m = 0; val_m = 0; dat_m = '0;
                q.delete();
                primed = 1'b1;
            end else begin
                int wc, rc;
                bit push, fire, req;
                wc = W - Rd2; rc = Wd2 - R; push = 0; fire = 0;
                if (mode_m != 2) begin
                    if (wr_en && wc == DEPTH) ovf_m = 1;
                    push = wr_en && (wc != DEPTH);
                    req  = rd_en && (mode_m == 1 || started_m);
                    if (req && rc == 0) unf_m = 1;
                    fire = req && (rc != 0);
                    if (mode_m == 0 && rc >= HALF) started_m = 1;
                    val_m = fire;
                    if (fire) dat_m = q.pop_front();
                    if (push) q.push_back(wr_data);
                end else begin
                    val_m = wr_en;
                    dat_m = wr_data;
                end
                Wd2 = Wd1; Wd1 = W; Rd2 = Rd1; Rd1 = R;
                W += int'(push); R += int'(fire);
            end
        end
    end

    always @(negedge clk_a) begin
        if (model_on && primed) begin
            int wc, rc;
            string dtag;
            wc = W - Rd2; rc = Wd2 - R;
            dtag = (mode_m == 0) ? "R2" : (mode_m == 1) ? "R10" : "R9";
            chk(wr_full == (wc == DEPTH), "R8", "wr_full", wr_full, wc == DEPTH);
            chk(wr_pfull == (wc >= DEPTH - GAP), "R6", "wr_pfull", wr_pfull, wc >= DEPTH - GAP);
            chk(rd_empty == (rc == 0), "R7", "rd_empty", rd_empty, rc == 0);
            chk(rd_pempty == (rc <= PEL), "R7", "rd_pempty", rd_pempty, rc <= PEL);
            chk(wr_overflow == ovf_m, "R3", "wr_overflow", wr_overflow, ovf_m);
            chk(rd_underflow == unf_m, "R4", "rd_underflow", rd_underflow, unf_m);
            chk(rd_valid == val_m, dtag, "rd_valid", rd_valid, val_m);
            chk(rd_data == dat_m, dtag, "rd_data", rd_data, dat_m);
        end
    end

    task automatic reset_same(input logic [1:0] code);
        @(negedge clk_a);
        wr_rst = 1'b1; rd_rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; mode_sel = code;
        repeat (4) @(negedge clk_a);
        wr_rst = 1'b0; rd_rst = 1'b0;
    endtask

    task automatic run_split(input realtime half, input int n);
        logic [WIDTH-1:0] sb[$];
        int sent, got;
        bit wdone;
        sent = 0; got = 0; wdone = 0;
        @(negedge clk_a);
        wr_rst = 1'b1; rd_rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        mode_sel = 2'd1; b_half = half; split = 1'b1;
        repeat (12) @(negedge clk_a);
        wr_rst = 1'b0;
        @(negedge clk_b);
        rd_rst = 1'b0;
        fork
            begin
                while (sent < n) begin
                    @(negedge clk_a);
                    if (!wr_pfull) begin
                        wr_en = 1'b1; wr_data = $urandom;
                        sb.push_back(wr_data); sent++;
                    end else wr_en = 1'b0;
                end
                @(negedge clk_a);
                wr_en = 1'b0; wdone = 1;
            end
            begin
                while (got < n) begin
                    @(negedge clk_b);
                    if (rd_valid) begin
                        logic [WIDTH-1:0] e;
                        e = sb.pop_front();
                        chk(rd_data == e, "R5", "ordered word", rd_data, e);
                        got++;
                    end
                    rd_en = wdone ? !rd_empty : !rd_pempty;
                end
                rd_en = 1'b0;
            end
        join
        repeat (4) @(negedge clk_a);
        chk(wr_overflow == 1'b0, "R5", "no overflow when throttled", wr_overflow, 0);
        chk(rd_underflow == 1'b0, "R5", "no underflow when throttled", rd_underflow, 0);
        chk(sb.size() == 0, "R5", "all words delivered", sb.size(), 0);
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        int cnt;
        model_on = 1'b1;
        cnt = 1;
        repeat (5) @(negedge clk_a);
        chk(rd_empty == 1'b1, "R7", "reset empty", rd_empty, 1);
        chk(rd_pempty == 1'b1, "R7", "reset pempty", rd_pempty, 1);
        chk(wr_full == 1'b0, "R8", "reset full", wr_full, 0);
        chk(rd_valid == 1'b0, "R10", "reset valid", rd_valid, 0);
        chk(wr_overflow == 1'b0, "R3", "reset overflow", wr_overflow, 0);
        chk(rd_underflow == 1'b0, "R4", "reset underflow", rd_underflow, 0);

        // phase compensation, enables held high
        wr_rst = 1'b0; rd_rst = 1'b0;
        for (int i = 0; i < 40; i++) begin
            wr_en = 1'b1; rd_en = 1'b1; wr_data = cnt++;
            if (i == 30) mode_sel = 2'd2;
            @(negedge clk_a);
        end
        wr_en = 1'b0;
        repeat (2) @(negedge clk_a);
        chk(rd_valid == 1'b1, "R1", "mode change after reset ignored", rd_valid, 1);
        repeat (14) @(negedge clk_a);

        // basic mode, shared clock: fill, overflow, drain, underflow, random
        reset_same(2'd1);
        for (int i = 0; i < 22; i++) begin
            wr_en = 1'b1; rd_en = 1'b0; wr_data = cnt++;
            @(negedge clk_a);
        end
        wr_en = 1'b0;
        chk(wr_overflow == 1'b1, "R3", "overflow after filling", wr_overflow, 1);
        for (int i = 0; i < 22; i++) begin
            rd_en = 1'b1;
            @(negedge clk_a);
        end
        chk(rd_underflow == 1'b1, "R4", "underflow after draining", rd_underflow, 1);
        for (int i = 0; i < 80; i++) begin
            wr_en = $urandom_range(0, 1); rd_en = $urandom_range(0, 1);
            wr_data = $urandom;
            @(negedge clk_a);
        end
        reset_same(2'd1);
        @(negedge clk_a);
        chk(wr_overflow == 1'b0, "R3", "overflow cleared by reset", wr_overflow, 0);

        // register mode
        reset_same(2'd2);
        for (int i = 0; i < 24; i++) begin
            wr_en = $urandom_range(0, 1); rd_en = $urandom_range(0, 1);
            wr_data = $urandom;
            @(negedge clk_a);
        end
        wr_en = 1'b1; wr_data = 32'hA5A5_0F0F;
        @(negedge clk_a);
        chk(rd_data == 32'hA5A5_0F0F, "R9", "bypass data", rd_data, 32'hA5A5_0F0F);
        chk(rd_valid == 1'b1, "R9", "bypass valid", rd_valid, 1);

        // code 3 also selects register mode
        reset_same(2'd3);
        for (int i = 0; i < 10; i++) begin
            wr_en = 1'b1; wr_data = cnt++;
            @(negedge clk_a);
        end
        chk(rd_empty == 1'b1, "R1", "code 3 stores nothing", rd_empty, 1);
        wr_en = 1'b0;
        @(negedge clk_a);
        model_on = 1'b0;

        // basic mode across unrelated clocks
        run_split(7.3, 200);
        run_split(2.9, 200);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_a);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule